// File: doc/BRIEF.md
# DRAM Refresh Scheduling Controller

This block decides when a single DRAM rank is refreshed. A free-running interval counter measures the average refresh period in clock cycles. Every time it expires, one more refresh becomes owed. Refreshes are not forced out at the moment they fall due. They are postponed and tracked as a count. The count is then turned into one of three urgency tiers, and a refresh request carrying that tier is presented to the command scheduler.

With only a few refreshes owed, the block asks for a refresh only when the rank has sat idle long enough, so the refresh is opportunistic. Once the owed count reaches a high watermark, the request becomes high priority. At a second, panic watermark it becomes panic priority. A coarse no-refresh limit timer also forces panic priority when it expires while refreshes are owed. The scheduler answers with a grant. The block then retires one owed refresh and holds off activates and further refreshes for the programmed execution time. A thermal input and a two-bit mode field can halve the effective interval, which doubles the refresh rate.

Top module: `refresh_sched`

## Requirements
- R1: While `rst_n` is low and just after it rises, `refresh_req`, `req_prio` and `block_act` are all 0, and the owed count, the idle count and all timers are cleared.
- R2: The interval counter expires once every L clock cycles, where L is the effective period. Each expiry raises the owed count by one. The first expiry after reset lands on the L-th rising edge. An effective period of 0 or 1 expires on every cycle.
- R3: The effective period is `cfg_interval` shifted right by one (halved) when doubling is active, and `cfg_interval` otherwise. `cfg_dbl_mode` sets doubling as follows:
  - 2'b01 always doubles.
  - 2'b10 never doubles.
  - 2'b00 and 2'b11 double only while `temp_hot` is 1.
- R4: `req_prio` is an encoded tier: 0 = none, 1 = opportunistic, 2 = high, 3 = panic. `refresh_req` is 1 exactly when `req_prio` is non-zero. The tier is 2 when the owed count is at least `cfg_hi_wm` and neither panic condition holds.
- R5: The tier is 3 when the owed count is non-zero and at least `cfg_panic_wm`. Panic takes precedence over high.
- R6: When the owed count is non-zero but below both watermarks, the tier is 1 only if `rank_idle` has been 1 for at least `cfg_idle_thr` consecutive cycles. Otherwise the tier is 0. Any cycle with `rank_idle` at 0 restarts the idle count at zero.
- R7: With no refresh owed, the tier is 0 whatever the idle state or the limit timer says.
- R8: A refresh is taken when `refresh_grant` and `refresh_req` are both 1 on a rising edge. Each taken refresh lowers the owed count by one. A grant while `refresh_req` is 0 has no effect.
- R9: After a taken refresh, `block_act` is 1 for exactly `cfg_exec_time` cycles, starting the next cycle. While `block_act` is 1, `refresh_req` is 0.
- R10: The no-refresh limit timer counts in units of 1024 cycles from reset or from the last taken refresh. Once it reaches `cfg_max_gap` units while refreshes are owed, the tier is forced to 3. A taken refresh restarts the timer.
- R11: The owed count saturates at 15 (all ones of its 4-bit width) and never wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_interval | input | 16 | Average refresh period in cycles |
| cfg_hi_wm | input | 4 | Owed count that raises the tier to high |
| cfg_panic_wm | input | 4 | Owed count that raises the tier to panic |
| cfg_idle_thr | input | 8 | Idle cycles that make an opportunity |
| cfg_exec_time | input | 9 | Refresh execution time in cycles |
| cfg_dbl_mode | input | 2 | Rate doubling mode |
| cfg_max_gap | input | 7 | No-refresh limit in 1024-cycle units |
| rank_idle | input | 1 | Rank currently idle |
| temp_hot | input | 1 | DRAM is warm or hot |
| refresh_grant | input | 1 | Scheduler accepts the refresh request |
| refresh_req | output | 1 | Refresh requested |
| req_prio | output | 2 | Request tier (0 none, 1 opp, 2 high, 3 panic) |
| block_act | output | 1 | Activates and refreshes held off |

## Verification
The bench checks that the owed count saturates at 15 instead of wrapping. A wrapping counter would fall from panic back to no request after 25 postponed refreshes. A stray grant that arrives during the execution window must not retire a refresh. If it did, the tier would drop from high to none once the window closes. Every doubling mode is tried with both temperature levels, so a mode 11 not treated like mode 00 moves the high-priority onset by a full interval. The limit timer is checked both with no refresh owed, where it must stay silent, and across a restart, where an unrestarted timer would raise panic about a thousand cycles early.

// File: rtl/rfs_pkg.sv
package rfs_pkg;
   typedef enum logic [1:0] {
      PRIO_NONE  = 2'd0,
      PRIO_OPP   = 2'd1,
      PRIO_HIGH  = 2'd2,
      PRIO_PANIC = 2'd3
   } rfs_prio_e;
endpackage

// File: rtl/rfs_interval_tick.sv
module rfs_interval_tick #(
   parameter int PERIOD_W = 16,
   parameter bit DBL_EN   = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [PERIOD_W-1:0] period,
   input  logic                dbl,
   output logic                tick
);
   logic [PERIOD_W-1:0] cnt;
   logic [PERIOD_W-1:0] limit;

   initial assert (PERIOD_W >= 2) else $fatal(1, "PERIOD_W too small");

   generate
      if (DBL_EN) begin : g_dbl
         assign limit = dbl ? (period >> 1) : period;
      end else begin : g_nodbl
         logic unused_dbl;
         assign unused_dbl = dbl;
         assign limit = period;
      end
   endgenerate

   assign tick = ({1'b0, cnt} + 1'b1) >= {1'b0, limit};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt <= '0;
      else if (tick) cnt <= '0;
      else           cnt <= cnt + 1'b1;
   end

   // R2: an expiry restarts the count, so two expiries in a row need a period of 0 or 1
   assert_tick_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && limit > 1 && $stable(limit)) |=> (!tick || limit <= 1));
endmodule

// File: rtl/rfs_owed_ctr.sv
module rfs_owed_ctr #(
   parameter int OWED_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              take,
   output logic [OWED_W-1:0] owed
);
   localparam logic [OWED_W-1:0] OWED_MAX = {OWED_W{1'b1}};

   logic [OWED_W-1:0] owed_nx;

   initial assert (OWED_W >= 2) else $fatal(1, "OWED_W too small");

   always_comb begin
      owed_nx = owed;
      unique case ({tick, take})
         2'b10:   if (owed != OWED_MAX) owed_nx = owed + 1'b1;
         2'b01:   if (owed != '0)       owed_nx = owed - 1'b1;
         default: owed_nx = owed;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) owed <= '0;
      else        owed <= owed_nx;
   end

   // R2, R8: the owed count moves by at most one per cycle
   assert_owed_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (owed == $past(owed) || owed == $past(owed) + 1'b1 || owed + 1'b1 == $past(owed)));
   // R11: a full count stays full unless a refresh is taken
   assert_owed_sat_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (owed == OWED_MAX && !take) |=> owed == OWED_MAX);
endmodule

// File: rtl/rfs_down_timer.sv
module rfs_down_timer #(
   parameter int W = 9
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic         busy
);
   logic [W-1:0] cnt;

   initial assert (W >= 1) else $fatal(1, "W too small");

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt <= '0;
      else if (load)       cnt <= load_val;
      else if (cnt != '0)  cnt <= cnt - 1'b1;
   end

   assign busy = (cnt != '0);

   // R9: a non-zero load opens the hold-off window on the next cycle
   assert_load_opens_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (load && load_val != '0) |=> busy);
   // R9: without a reload the window shrinks by exactly one each cycle
   assert_count_down_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !load) |=> (cnt + 1'b1 == $past(cnt)));
endmodule

// File: rtl/rfs_gap_timer.sv
module rfs_gap_timer #(
   parameter int UNIT_LOG2 = 10,
   parameter int GAP_W     = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart,
   input  logic [GAP_W-1:0] limit,
   output logic             expired
);
   logic [UNIT_LOG2-1:0] pre;
   logic [GAP_W-1:0]     units;

   initial assert (UNIT_LOG2 >= 1 && GAP_W >= 1) else $fatal(1, "bad gap timer widths");

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pre   <= '0;
         units <= '0;
      end else if (restart) begin
         pre   <= '0;
         units <= '0;
      end else begin
         pre <= pre + 1'b1;
         if (&pre && units != {GAP_W{1'b1}}) units <= units + 1'b1;
      end
   end

   assign expired = (units >= limit);

   // R10: a restart clears the limit unless the limit itself is zero
   assert_restart_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> (!expired || limit == '0));
endmodule

// File: rtl/refresh_sched.sv
module refresh_sched
   import rfs_pkg::*;
#(
   parameter int PERIOD_W  = 16,
   parameter int WM_W      = 4,
   parameter int OWED_W    = 4,
   parameter int IDLE_W    = 8,
   parameter int EXEC_W    = 9,
   parameter int GAP_W     = 7,
   parameter int UNIT_LOG2 = 10,
   parameter bit DBL_EN    = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [PERIOD_W-1:0] cfg_interval,
   input  logic [WM_W-1:0]     cfg_hi_wm,
   input  logic [WM_W-1:0]     cfg_panic_wm,
   input  logic [IDLE_W-1:0]   cfg_idle_thr,
   input  logic [EXEC_W-1:0]   cfg_exec_time,
   input  logic [1:0]          cfg_dbl_mode,
   input  logic [GAP_W-1:0]    cfg_max_gap,
   input  logic                rank_idle,
   input  logic                temp_hot,
   input  logic                refresh_grant,
   output logic                refresh_req,
   output logic [1:0]          req_prio,
   output logic                block_act
);
   initial assert (OWED_W >= WM_W) else $fatal(1, "owed count narrower than watermarks");

   logic              dbl, tick, take, gap_exp, idle_ok;
   logic [OWED_W-1:0] owed;
   logic [IDLE_W-1:0] idle_cnt;
   rfs_prio_e         prio;

   assign dbl  = (cfg_dbl_mode == 2'b01) || ((cfg_dbl_mode != 2'b10) && temp_hot);
   assign take = refresh_grant && refresh_req;

   rfs_interval_tick #(.PERIOD_W(PERIOD_W), .DBL_EN(DBL_EN)) u_tick (
      .clk(clk), .rst_n(rst_n), .period(cfg_interval), .dbl(dbl), .tick(tick));

   rfs_owed_ctr #(.OWED_W(OWED_W)) u_owed (
      .clk(clk), .rst_n(rst_n), .tick(tick), .take(take), .owed(owed));

   rfs_down_timer #(.W(EXEC_W)) u_exec (
      .clk(clk), .rst_n(rst_n), .load(take), .load_val(cfg_exec_time), .busy(block_act));

   rfs_gap_timer #(.UNIT_LOG2(UNIT_LOG2), .GAP_W(GAP_W)) u_gap (
      .clk(clk), .rst_n(rst_n), .restart(take), .limit(cfg_max_gap), .expired(gap_exp));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      idle_cnt <= '0;
      else if (!rank_idle)             idle_cnt <= '0;
      else if (idle_cnt != '1)         idle_cnt <= idle_cnt + 1'b1;
   end

   assign idle_ok = (idle_cnt >= cfg_idle_thr);

   always_comb begin
      prio = PRIO_NONE;
      if (owed != '0 && !block_act) begin
         if (owed >= OWED_W'(cfg_panic_wm) || gap_exp) prio = PRIO_PANIC;
         else if (owed >= OWED_W'(cfg_hi_wm))          prio = PRIO_HIGH;
         else if (idle_ok)                             prio = PRIO_OPP;
      end
   end

   assign req_prio    = prio;
   assign refresh_req = (prio != PRIO_NONE);

   // R9: nothing is requested inside the execution window
   assert_no_req_blocked_R9: assert property (@(posedge clk) disable iff (!rst_n)
      block_act |-> !refresh_req);
   // R7: an empty owed count never asks for a refresh
   assert_none_when_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (owed == '0) |-> (req_prio == PRIO_NONE));
   // R8: a taken refresh starts the window when the execution time is non-zero
   assert_take_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (take && cfg_exec_time != '0) |=> block_act);
endmodule

// File: tb/sim_refresh_sched.sv
`timescale 1ns/100ps
module sim_refresh_sched;
   typedef struct {
      logic [1:0] prio;
      logic       blk;
      string      tag;
   } sb_item_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] cfg_interval = 16'd20;
   logic [3:0]  cfg_hi_wm = 4'd8;
   logic [3:0]  cfg_panic_wm = 4'd9;
   logic [7:0]  cfg_idle_thr = 8'd255;
   logic [8:0]  cfg_exec_time = 9'd6;
   logic [1:0]  cfg_dbl_mode = 2'b10;
   logic [6:0]  cfg_max_gap = 7'd127;
   logic        rank_idle = 1'b0;
   logic        temp_hot = 1'b0;
   logic        refresh_grant = 1'b0;
   logic        refresh_req;
   logic [1:0]  req_prio;
   logic        block_act;

   int total = 0;
   int bad = 0;
   int edges = 0;
   bit done = 1'b0;
   sb_item_t sb_q[$];
   event sb_ev;

   always #2.5 clk = ~clk;

   refresh_sched u0 (
      .clk(clk), .rst_n(rst_n), .cfg_interval(cfg_interval), .cfg_hi_wm(cfg_hi_wm),
      .cfg_panic_wm(cfg_panic_wm), .cfg_idle_thr(cfg_idle_thr), .cfg_exec_time(cfg_exec_time),
      .cfg_dbl_mode(cfg_dbl_mode), .cfg_max_gap(cfg_max_gap), .rank_idle(rank_idle),
      .temp_hot(temp_hot), .refresh_grant(refresh_grant), .refresh_req(refresh_req),
      .req_prio(req_prio), .block_act(block_act));

   // monitor: pops expected items and compares them with the outputs
   initial begin
      forever begin
         @(sb_ev);
         while (sb_q.size() != 0) begin
            sb_item_t it;
            it = sb_q.pop_front();
            total++;
            if (req_prio !== it.prio || block_act !== it.blk || refresh_req !== (it.prio != 2'd0)) begin
               bad++;
               $display("FAIL %s: prio=%0d req=%0b blk=%0b expected prio=%0d req=%0b blk=%0b",
                        it.tag, req_prio, refresh_req, block_act, it.prio, (it.prio != 2'd0), it.blk);
            end
         end
      end
   end

   task automatic expect_out(input logic [1:0] p, input logic b, input string tag);
      sb_item_t it;
      it.prio = p;
      it.blk  = b;
      it.tag  = tag;
      sb_q.push_back(it);
      -> sb_ev;
      #1;
   endtask

   task automatic go_to(input int e);
      while (edges < e) begin
         @(negedge clk);
         edges++;
      end
   endtask

   task automatic grant_at(input int e);
      go_to(e - 1);
      refresh_grant = 1'b1;
      go_to(e);
      refresh_grant = 1'b0;
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      refresh_grant = 1'b0;
      repeat (3) @(negedge clk);
      expect_out(2'd0, 1'b0, "R1 in reset");
      rst_n = 1'b1;
      edges = 0;
   endtask

   task automatic run_dbl(input logic [1:0] m, input logic t, input int at);
      cfg_interval = 16'd20; cfg_hi_wm = 4'd2; cfg_panic_wm = 4'd9;
      cfg_idle_thr = 8'd255; rank_idle = 1'b0; cfg_max_gap = 7'd127;
      cfg_dbl_mode = m; temp_hot = t;
      do_reset();
      go_to(at - 1);
      expect_out(2'd0, 1'b0, $sformatf("R3 mode=%0d hot=%0b before", m, t));
      go_to(at);
      expect_out(2'd2, 1'b0, $sformatf("R3 mode=%0d hot=%0b onset", m, t));
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         bad++;
         total++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      // R1, R2, R4, R5, R8, R9: postponed refreshes climb the tiers, then a grant
      cfg_interval = 16'd20; cfg_hi_wm = 4'd4; cfg_panic_wm = 4'd5; cfg_exec_time = 9'd6;
      cfg_dbl_mode = 2'b10; cfg_idle_thr = 8'd255; cfg_max_gap = 7'd127;
      do_reset();
      go_to(1);
      expect_out(2'd0, 1'b0, "R1 after reset");
      go_to(79);
      expect_out(2'd0, 1'b0, "R2 three owed");
      go_to(80);
      expect_out(2'd2, 1'b0, "R4 high at watermark");
      go_to(99);
      expect_out(2'd2, 1'b0, "R4 still high");
      go_to(100);
      expect_out(2'd3, 1'b0, "R5 panic at watermark");
      grant_at(101);
      expect_out(2'd0, 1'b1, "R9 blocked after grant");
      grant_at(103);
      go_to(106);
      expect_out(2'd0, 1'b1, "R9 last blocked cycle");
      go_to(107);
      expect_out(2'd2, 1'b0, "R8 one retired, stray grant ignored");

      // R6, R7: opportunistic refresh on an idle rank
      cfg_hi_wm = 4'd8; cfg_panic_wm = 4'd9; cfg_idle_thr = 8'd5; rank_idle = 1'b1;
      do_reset();
      go_to(19);
      expect_out(2'd0, 1'b0, "R7 idle but nothing owed");
      go_to(20);
      expect_out(2'd1, 1'b0, "R6 opportunistic");
      grant_at(21);
      expect_out(2'd0, 1'b1, "R8 grant of opportunistic refresh");
      rank_idle = 1'b0;
      go_to(40);
      expect_out(2'd0, 1'b0, "R6 owed but busy rank");
      rank_idle = 1'b1;
      go_to(44);
      expect_out(2'd0, 1'b0, "R6 idle below threshold");
      go_to(45);
      expect_out(2'd1, 1'b0, "R6 idle threshold reached");
      rank_idle = 1'b0;
      go_to(46);
      expect_out(2'd0, 1'b0, "R6 idle count restarts");

      // R3: doubling modes
      run_dbl(2'b00, 1'b0, 40);
      run_dbl(2'b00, 1'b1, 20);
      run_dbl(2'b01, 1'b0, 20);
      run_dbl(2'b10, 1'b1, 40);
      run_dbl(2'b11, 1'b1, 20);
      run_dbl(2'b11, 1'b0, 40);

      // R11: saturation
      cfg_interval = 16'd8; cfg_hi_wm = 4'd14; cfg_panic_wm = 4'd15; cfg_dbl_mode = 2'b10;
      temp_hot = 1'b0; cfg_idle_thr = 8'd255; rank_idle = 1'b0; cfg_max_gap = 7'd127;
      do_reset();
      go_to(200);
      expect_out(2'd3, 1'b0, "R11 saturated at 15");
      grant_at(201);
      go_to(207);
      expect_out(2'd2, 1'b0, "R11 15 minus one");

      // R10, R7: no-refresh limit timer
      cfg_interval = 16'd5000; cfg_hi_wm = 4'd8; cfg_panic_wm = 4'd9; cfg_max_gap = 7'd1;
      do_reset();
      go_to(1100);
      expect_out(2'd0, 1'b0, "R7 limit expired, nothing owed");
      cfg_interval = 16'd300;
      do_reset();
      go_to(1023);
      expect_out(2'd0, 1'b0, "R10 before limit");
      go_to(1024);
      expect_out(2'd3, 1'b0, "R10 limit forces panic");
      grant_at(1025);
      go_to(1040);
      expect_out(2'd0, 1'b0, "R10 timer restarted");
      go_to(2048);
      expect_out(2'd0, 1'b0, "R10 before second limit");
      go_to(2049);
      expect_out(2'd3, 1'b0, "R10 second limit");

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule